// File: doc/BRIEF.md
# Binary-Field Modular Divider

This block divides one element of GF(2^163) by another: given a dividend g(x) and a nonzero divisor h(x), it returns q(x) = g(x)·h(x)^-1 mod f(x). The field polynomial is f(x) = x^163 + x^7 + x^6 + x^3 + 1. Setting the dividend to 1 yields the multiplicative inverse of the divisor. The block uses the binary extended-GCD method. Two polynomial pairs are shifted toward each other, and two signed degree counters decide when the pairs swap roles. Division by x modulo f keeps the cofactor registers reduced. The block performs one iteration per clock.

Operands arrive on a valid/ready input channel and the quotient leaves on a valid/ready output channel. The input is accepted in a cycle where `in_valid` and `in_ready` are both high. After that, `in_ready` stays low until the quotient has been taken. The quotient is presented with `out_valid` and is held unchanged while the consumer keeps `out_ready` low. Only one division is in flight at a time. Operands must already be reduced, with degree below 163. A zero divisor gives an unspecified quotient, but the operation still completes.

Top module: `gf2m_divider`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R2: An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `busy` is 1 and `in_ready` is 0, and changes on `in_g`, `in_h` or `in_valid` have no effect on the result under way.
- R3: For any nonzero h, the quotient satisfies out_q·h mod f = g, with f = x^163 + x^7 + x^6 + x^3 + 1 and bit i of each bus being the coefficient of x^i.
- R4: With g = 1 the quotient is the inverse of h, so out_q·h mod f = 1.
- R5: With h = 1 the quotient equals g.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_q` stays stable on the next cycle. After a cycle with both high, `out_valid` is 0 and `in_ready` is 1.
- R7: `out_valid` rises no more than 2·163+1 cycles after the acceptance edge, for every operand pair including h = 0.
- R8: With g = 0 and h nonzero, the quotient is 0.
- R9: `busy` and `out_valid` are never 1 in the same cycle, and the internal left-hand polynomial stays odd while iterating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can accept an operand pair |
| in_g | input | 163 | Dividend g(x) |
| in_h | input | 163 | Divisor h(x), nonzero |
| out_valid | output | 1 | Quotient is presented |
| out_ready | input | 1 | Consumer takes the quotient |
| out_q | output | 163 | Quotient g/h mod f |
| busy | output | 1 | Division iterations in progress |

## Verification
Several properties are checked on every cycle: the handshake rules, the hold of a stalled quotient, the mutual exclusion of `busy` and `out_valid`, and the oddness of the left-hand polynomial. A counter in the checker bounds how long `busy` may stay high. The algebraic correctness of the quotient can only be shown by the bench scenarios. These cover inverses, a unit divisor, a zero dividend and random pairs, each checked against an independent multiply-and-reduce model. The same applies to ignoring inputs mid-run and to termination with a zero divisor.

// File: rtl/gf2m_div_pkg.sv
package gf2m_div_pkg;
  // field degree and reduction polynomial x^163 + x^7 + x^6 + x^3 + 1
  localparam int unsigned FIELD_M = 163;
  localparam logic [FIELD_M:0] FIELD_POLY = {1'b1, 155'd0, 8'b1100_1001};

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;
endpackage

// File: rtl/gf2m_xdiv.sv
// Combinational division by x modulo the field polynomial.
module gf2m_xdiv #(
  parameter int unsigned M = 163,
  parameter logic [M:0] POLY = gf2m_div_pkg::FIELD_POLY
) (
  input  logic [M-1:0] din,
  output logic [M-1:0] dout
);
  logic [M:0] folded;

  // an odd value gets f added first so the constant term cancels
  assign folded = {1'b0, din} ^ (din[0] ? POLY : '0);
  assign dout   = M'(folded >> 1);
endmodule

// File: rtl/gf2m_div_step.sv
// One iteration of the two-counter binary division.
module gf2m_div_step #(
  parameter int unsigned M = 163,
  parameter logic [M:0] POLY = gf2m_div_pkg::FIELD_POLY,
  parameter int unsigned CW = 10
) (
  input  logic [M:0]           a_cur,
  input  logic [M-1:0]         b_cur,
  input  logic [M-1:0]         c_cur,
  input  logic [M-1:0]         d_cur,
  input  logic signed [CW-1:0] alpha_cur,
  input  logic signed [CW-1:0] beta_cur,
  output logic [M:0]           a_nxt,
  output logic [M-1:0]         b_nxt,
  output logic [M-1:0]         c_nxt,
  output logic [M-1:0]         d_nxt,
  output logic signed [CW-1:0] alpha_nxt,
  output logic signed [CW-1:0] beta_nxt
);
  logic         b_odd;
  logic [M-1:0] xdiv_in;
  logic [M-1:0] xdiv_out;

  assign b_odd   = b_cur[0];
  assign xdiv_in = b_odd ? (c_cur ^ d_cur) : d_cur;

  gf2m_xdiv #(.M(M), .POLY(POLY)) xdiv_i (
    .din  (xdiv_in),
    .dout (xdiv_out)
  );

  always_comb begin
    a_nxt     = a_cur;
    c_nxt     = c_cur;
    alpha_nxt = alpha_cur;
    beta_nxt  = beta_cur - CW'(1);
    d_nxt     = xdiv_out;
    if (!b_odd) begin
      b_nxt = b_cur >> 1;
    end else begin
      b_nxt = M'((a_cur ^ {1'b0, b_cur}) >> 1);
      if (alpha_cur > beta_cur) begin
        // the pairs exchange roles and the degree bounds swap
        a_nxt     = {1'b0, b_cur};
        c_nxt     = d_cur;
        beta_nxt  = alpha_cur - CW'(1);
        alpha_nxt = beta_cur;
      end
    end
  end
endmodule

// File: rtl/gf2m_divider.sv
module gf2m_divider #(
  parameter int unsigned M = gf2m_div_pkg::FIELD_M,
  parameter logic [M:0] POLY = gf2m_div_pkg::FIELD_POLY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_g,
  input  logic [M-1:0] in_h,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_q,
  output logic         busy
);
  import gf2m_div_pkg::*;

  localparam int unsigned CW = $clog2(M + 1) + 2;

  div_state_e          state_q;
  logic [M:0]          a_q, a_n;
  logic [M-1:0]        b_q, b_n, c_q, c_n, d_q, d_n;
  logic signed [CW-1:0] alpha_q, alpha_n, beta_q, beta_n;
  logic                loop_end;

  gf2m_div_step #(.M(M), .POLY(POLY), .CW(CW)) step_i (
    .a_cur     (a_q),
    .b_cur     (b_q),
    .c_cur     (c_q),
    .d_cur     (d_q),
    .alpha_cur (alpha_q),
    .beta_cur  (beta_q),
    .a_nxt     (a_n),
    .b_nxt     (b_n),
    .c_nxt     (c_n),
    .d_nxt     (d_n),
    .alpha_nxt (alpha_n),
    .beta_nxt  (beta_n)
  );

  assign loop_end = beta_q < 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      d_q     <= '0;
      alpha_q <= '0;
      beta_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            a_q     <= POLY;
            b_q     <= in_h;
            c_q     <= '0;
            d_q     <= in_g;
            alpha_q <= CW'(M);
            beta_q  <= CW'(M - 1);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (loop_end) begin
            state_q <= ST_DONE;
          end else begin
            a_q     <= a_n;
            b_q     <= b_n;
            c_q     <= c_n;
            d_q     <= d_n;
            alpha_q <= alpha_n;
            beta_q  <= beta_n;
          end
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_RUN);
  assign out_valid = (state_q == ST_DONE);
  assign out_q     = c_q;
endmodule

// File: rtl/gf2m_divider_chk.sv
module gf2m_divider_chk #(
  parameter int unsigned M = 163,
  parameter int unsigned CW = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [M-1:0]         out_q,
  input logic                 busy,
  input logic                 a_lsb,
  input logic signed [CW-1:0] alpha
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !in_ready);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_q));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && out_valid));

  assert_left_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> a_lsb);

  assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= 16'(2 * M)) && (alpha >= 0));
endmodule

bind gf2m_divider gf2m_divider_chk #(.M(M), .CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_q     (out_q),
  .busy      (busy),
  .a_lsb     (a_q[0]),
  .alpha     (alpha_q)
);

// File: tb/gf2m_divider_tb_top.sv
`timescale 1ns/1ps
module gf2m_divider_tb_top;
  localparam int unsigned M = gf2m_div_pkg::FIELD_M;
  localparam logic [M:0] F = gf2m_div_pkg::FIELD_POLY;
  localparam int MAX_LAT = 2 * M + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [M-1:0] in_g = '0;
  logic [M-1:0] in_h = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [M-1:0] out_q;
  logic         busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  gf2m_divider dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_g(in_g), .in_h(in_h), .out_valid(out_valid), .out_ready(out_ready),
    .out_q(out_q), .busy(busy)
  );

  function automatic logic [M-1:0] gfmul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M:0]   acc;
    logic [M-1:0] r;
    r   = '0;
    acc = {1'b0, x};
    for (int i = 0; i < M; i++) begin
      if (y[i]) r = r ^ acc[M-1:0];
      acc = acc << 1;
      if (acc[M]) acc = acc ^ F;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] rnd_elem();
    logic [191:0] w;
    w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return w[M-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act,
                       input logic [M-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // offer a pair, wait for the quotient; leaves out_valid pending
  task automatic launch(input logic [M-1:0] g, input logic [M-1:0] h,
                        output logic [M-1:0] q, output int lat);
    @(negedge clk);
    in_g = g; in_h = h; in_valid = 1'b1; out_ready = 1'b0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    q = out_q;
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic test_reset();
    check(in_ready == 1'b1, "R1 in_ready", M'(in_ready), M'(1));
    check(out_valid == 1'b0, "R1 out_valid", M'(out_valid), M'(0));
    check(busy == 1'b0, "R1 busy", M'(busy), M'(0));
  endtask

  task automatic test_inverse();
    logic [M-1:0] q, h;
    int lat;
    for (int k = 0; k < 4; k++) begin
      h = (k == 0) ? M'(1) : (k == 1) ? M'(2) : rnd_elem();
      if (h == '0) h = M'(3);
      launch(M'(1), h, q, lat);
      check(gfmul(q, h) == M'(1), "R4 inverse", gfmul(q, h), M'(1));
      check(lat <= MAX_LAT, "R7 latency", M'(lat), M'(MAX_LAT));
      take();
    end
  endtask

  task automatic test_unit_divisor();
    logic [M-1:0] q, g;
    int lat;
    for (int k = 0; k < 3; k++) begin
      g = rnd_elem();
      launch(g, M'(1), q, lat);
      check(q == g, "R5 unit divisor", q, g);
      take();
    end
  endtask

  task automatic test_random();
    logic [M-1:0] q, g, h;
    int lat;
    for (int k = 0; k < 8; k++) begin
      g = rnd_elem();
      h = rnd_elem();
      if (k == 0) h = {1'b1, {(M-1){1'b0}}};
      if (h == '0) h = M'(5);
      launch(g, h, q, lat);
      check(gfmul(q, h) == g, "R3 quotient", gfmul(q, h), g);
      check(lat <= MAX_LAT, "R7 latency", M'(lat), M'(MAX_LAT));
      take();
    end
  endtask

  task automatic test_zero_dividend();
    logic [M-1:0] q;
    int lat;
    launch('0, rnd_elem() | M'(1), q, lat);
    check(q == '0, "R8 zero dividend", q, '0);
    take();
  endtask

  task automatic test_backpressure();
    logic [M-1:0] q, g, h;
    int lat;
    g = rnd_elem();
    h = rnd_elem() | M'(8);
    launch(g, h, q, lat);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6 held valid", M'(out_valid), M'(1));
      check(out_q == q, "R6 stable quotient", out_q, q);
    end
    take();
    check(out_valid == 1'b0, "R6 released", M'(out_valid), M'(0));
    check(in_ready == 1'b1, "R6 ready again", M'(in_ready), M'(1));
  endtask

  task automatic test_busy_ignore();
    logic [M-1:0] g, h;
    int lat;
    g = rnd_elem();
    h = rnd_elem() | M'(16);
    @(negedge clk);
    in_g = g; in_h = h; in_valid = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after accept", M'(busy), M'(1));
    check(in_ready == 1'b0, "R2 not ready", M'(in_ready), M'(0));
    lat = 0;
    while (!out_valid && lat < 5000) begin
      in_g = rnd_elem();
      in_h = rnd_elem();
      in_valid = lat[0];
      if (busy && out_valid) check(1'b0, "R9 exclusive", M'(1), M'(0));
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check(gfmul(out_q, h) == g, "R2 inputs ignored", gfmul(out_q, h), g);
    take();
  endtask

  task automatic test_zero_divisor();
    logic [M-1:0] q;
    int lat;
    launch(rnd_elem(), '0, q, lat);
    check(lat <= MAX_LAT, "R7 zero divisor ends", M'(lat), M'(MAX_LAT));
    take();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_inverse();
    test_unit_divisor();
    test_random();
    test_zero_dividend();
    test_backpressure();
    test_busy_ignore();
    test_zero_divisor();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule